// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel Port Group

This block models a group of four 8-pin parallel ports, each built from one bit slice repeated per pin. Every pin has an output latch loaded from the internal bus. A pin is represented logically: each slice decides whether it pulls the pin low, whether it actively drives it high, and what level it then senses. Three signals decide the sensed level: the slice's own drive, an external sink input, and a weak idle level. The idle level is an internal pull-up on most ports. On the multiplexed port it is an explicit external pull-up level. Software-style reads choose between the sensed pin levels and the latch contents. Read-modify-write sequences read the latch, so a pin held low from outside cannot corrupt the value written back.

The four ports differ only in their slice variant, and the port index picks that variant. Port 0 is the multiplexed low-address/data port. In I/O mode it is open-drain, and in bus mode it drives both levels. Port 1 is the plain port. Port 2 is the high-address port, which in bus mode puts the high address byte on its pins in place of the latch. Port 3 is the alternate-function port. Its alternate outputs are gated by the latch, and it returns pin levels on an alternate input path. Because a latch is reset to 1, every pin starts out usable as an input.

Top module: `qbp_port_group`

## Requirements
- R1: After reset, every latch bit of all four ports reads 1. With no external sink, the pins of ports 1 to 3 read 1 and the pins of port 0 equal `float_lvl0`.
- R2: A write with `wr_en` high loads `wr_data` into the latch of port `wr_port` at the next rising clock edge. Port encoding is 0 = multiplexed, 1 = plain, 2 = high-address, 3 = alternate. The other ports' latches are unchanged, a latch holds its value while no write targets it, and the pin drive follows the new latch value in the same cycle the latch changes.
- R3: `rd_data` returns the sensed pin levels of port `rd_port` when `rd_latch` is 0 and that port's latch contents when `rd_latch` is 1. A latch bit of 1 with an externally sunk pin reads 0 on the pin path and 1 on the latch path.
- R4: On ports 1 and 2 in I/O mode, a pin whose latch bit is 0 reads 0 whatever the external level. A pin whose latch bit is 1 reads 0 when its `ext_low` bit is 1 and 1 otherwise.
- R5: With `bus_mode` low, port 0 never drives a pin high. A pin reads 0 if its latch bit is 0 or its `ext_low0` bit is 1; otherwise it reads the matching `float_lvl0` bit.
- R6: With `bus_mode` high, port 0 ignores its latch. If `bus_lo_oe` is 1, its pins equal `bus_lo` regardless of external sinks. If `bus_lo_oe` is 0, the pins are released and read 0 where `ext_low0` is 1 and `float_lvl0` elsewhere.
- R7: With `bus_mode` high, port 2 pins follow `bus_hi`, reading 0 where `ext_low2` is 1. The latch is retained and drives the pins again once `bus_mode` falls.
- R8: A port 3 pin reads 1 only when its latch bit, its `alt_out` bit and the inverse of its `ext_low3` bit are all 1.
- R9: An `alt_in` bit equals the port 3 pin level when both the latch bit and the `alt_out` bit are 1, and is 0 otherwise.
- R10: A latch write to port 0 while `bus_mode` is high updates the latch without disturbing the bus-driven pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, sets all latches to 1 |
| wr_en | input | 1 | Latch write strobe |
| wr_port | input | 2 | Port whose latch is written |
| wr_data | input | 8 | Data for the latch write |
| rd_port | input | 2 | Port selected for reading |
| rd_latch | input | 1 | 1 = read latch, 0 = read pin levels |
| rd_data | output | 8 | Read result |
| bus_mode | input | 1 | Ports 0 and 2 carry address/data instead of latch data |
| bus_lo_oe | input | 1 | Port 0 actively drives `bus_lo` in bus mode |
| bus_lo | input | 8 | Low address or outgoing data byte |
| bus_hi | input | 8 | High address byte |
| alt_out | input | 8 | Alternate-function outputs for port 3 |
| alt_in | output | 8 | Alternate-function inputs from port 3 |
| ext_low0 | input | 8 | External sink on port 0 pins |
| ext_low1 | input | 8 | External sink on port 1 pins |
| ext_low2 | input | 8 | External sink on port 2 pins |
| ext_low3 | input | 8 | External sink on port 3 pins |
| float_lvl0 | input | 8 | Level seen on undriven port 0 pins (external pull-up) |
| pin0 | output | 8 | Sensed levels of port 0 pins |
| pin1 | output | 8 | Sensed levels of port 1 pins |
| pin2 | output | 8 | Sensed levels of port 2 pins |
| pin3 | output | 8 | Sensed levels of port 3 pins |

## Verification
A latch write and a read of the same port can fall in the same cycle. The bench issues a write to a port and, in the cycle before the edge, reads its latch. The read must still return the old contents, and the new value must appear only after the edge. A latch write to port 0 can also coincide with bus-mode driving. The bench writes port 0 while `bus_lo` is on its pins, checks that the pins still carry `bus_lo`, and then checks that the written value governs the pins once bus mode ends.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

  typedef enum logic [1:0] {
    KIND_ADDR_DATA = 2'd0,
    KIND_PLAIN     = 2'd1,
    KIND_ADDR_HI   = 2'd2,
    KIND_ALT       = 2'd3
  } port_kind_e;

  localparam int NUM_PORTS = 4;

  // Slice variant chosen by port position.
  function automatic port_kind_e kind_of_port(input int idx);
    return port_kind_e'(idx[1:0]);
  endfunction

  // Wired pin resolution: active high drive wins, then any sink, then idle level.
  function automatic logic resolve_pin(input logic drv_hi, input logic drv_lo,
                                       input logic ext_low, input logic idle_lvl);
    if (drv_hi) return 1'b1;
    if (drv_lo || ext_low) return 1'b0;
    return idle_lvl;
  endfunction

  // Alternate output reaches the pin only through a latch holding 1.
  function automatic logic alt_gate(input logic latch_bit, input logic alt_bit);
    return latch_bit & alt_bit;
  endfunction

endpackage

// File: rtl/qbp_pin_slice.sv
module qbp_pin_slice
  import qbp_pkg::*;
#(
  parameter port_kind_e KIND = KIND_PLAIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic bus_mode,
  input  logic bus_oe,
  input  logic bus_bit,
  input  logic alt_o,
  input  logic ext_low,
  input  logic float_lvl,
  output logic latch_q,
  output logic pin,
  output logic alt_i,
  output logic drv_lo,
  output logic drv_hi
);

  localparam bit IS_AD  = (KIND == KIND_ADDR_DATA);
  localparam bit IS_HI  = (KIND == KIND_ADDR_HI);
  localparam bit IS_ALT = (KIND == KIND_ALT);

  logic src;
  logic idle_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  latch_q <= 1'b1;
    else if (wr) latch_q <= wdata;
  end

  always_comb begin
    src = latch_q;
    if (IS_ALT)             src = alt_gate(latch_q, alt_o);
    if (IS_HI && bus_mode)  src = bus_bit;
    drv_hi = 1'b0;
    drv_lo = ~src;
    if (IS_AD && bus_mode) begin
      drv_hi = bus_oe & bus_bit;
      drv_lo = bus_oe & ~bus_bit;
    end
    idle_lvl = IS_AD ? float_lvl : 1'b1;
    pin      = resolve_pin(drv_hi, drv_lo, ext_low, idle_lvl);
    alt_i    = IS_ALT ? (alt_gate(latch_q, alt_o) & pin) : 1'b0;
  end

endmodule

// File: rtl/qbp_port.sv
module qbp_port
  import qbp_pkg::*;
#(
  parameter int         WIDTH = 8,
  parameter port_kind_e KIND  = KIND_PLAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             bus_mode,
  input  logic             bus_oe,
  input  logic [WIDTH-1:0] bus_val,
  input  logic [WIDTH-1:0] alt_o,
  input  logic [WIDTH-1:0] ext_low,
  input  logic [WIDTH-1:0] float_lvl,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] alt_i,
  output logic [WIDTH-1:0] drv_lo,
  output logic [WIDTH-1:0] drv_hi
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    qbp_pin_slice #(.KIND(KIND)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr),
      .wdata    (wdata[b]),
      .bus_mode (bus_mode),
      .bus_oe   (bus_oe),
      .bus_bit  (bus_val[b]),
      .alt_o    (alt_o[b]),
      .ext_low  (ext_low[b]),
      .float_lvl(float_lvl[b]),
      .latch_q  (latch_q[b]),
      .pin      (pin[b]),
      .alt_i    (alt_i[b]),
      .drv_lo   (drv_lo[b]),
      .drv_hi   (drv_hi[b])
    );
  end

endmodule

// File: rtl/qbp_read_mux.sv
module qbp_read_mux #(
  parameter int WIDTH = 8,
  parameter int NPORT = 4,
  localparam int SELW = $clog2(NPORT)
) (
  input  logic [NPORT-1:0][WIDTH-1:0] latch_pk,
  input  logic [NPORT-1:0][WIDTH-1:0] pin_pk,
  input  logic [SELW-1:0]             sel,
  input  logic                        use_latch,
  output logic [WIDTH-1:0]            data
);

  always_comb begin
    data = use_latch ? latch_pk[sel] : pin_pk[sel];
  end

endmodule

// File: rtl/qbp_port_group.sv
module qbp_port_group
  import qbp_pkg::*;
#(
  parameter int W = 8,
  localparam int SELW = $clog2(NUM_PORTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_port,
  input  logic [W-1:0]    wr_data,
  input  logic [SELW-1:0] rd_port,
  input  logic            rd_latch,
  output logic [W-1:0]    rd_data,
  input  logic            bus_mode,
  input  logic            bus_lo_oe,
  input  logic [W-1:0]    bus_lo,
  input  logic [W-1:0]    bus_hi,
  input  logic [W-1:0]    alt_out,
  output logic [W-1:0]    alt_in,
  input  logic [W-1:0]    ext_low0,
  input  logic [W-1:0]    ext_low1,
  input  logic [W-1:0]    ext_low2,
  input  logic [W-1:0]    ext_low3,
  input  logic [W-1:0]    float_lvl0,
  output logic [W-1:0]    pin0,
  output logic [W-1:0]    pin1,
  output logic [W-1:0]    pin2,
  output logic [W-1:0]    pin3
);

  // Named internal wires, also observed by the bound checker.
  logic [NUM_PORTS-1:0][W-1:0] latch_pk;
  logic [NUM_PORTS-1:0][W-1:0] pin_pk;
  logic [NUM_PORTS-1:0][W-1:0] alt_pk;
  logic [NUM_PORTS-1:0][W-1:0] drv_lo_pk;
  logic [NUM_PORTS-1:0][W-1:0] drv_hi_pk;
  logic [NUM_PORTS-1:0][W-1:0] ext_pk;
  logic [NUM_PORTS-1:0]        wr_hit;

  assign ext_pk = {ext_low3, ext_low2, ext_low1, ext_low0};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam port_kind_e PK = kind_of_port(p);
    assign wr_hit[p] = wr_en && (wr_port == SELW'(p));
    qbp_port #(.WIDTH(W), .KIND(PK)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_hit[p]),
      .wdata    (wr_data),
      .bus_mode (bus_mode),
      .bus_oe   (bus_lo_oe),
      .bus_val  ((PK == KIND_ADDR_HI) ? bus_hi : bus_lo),
      .alt_o    (alt_out),
      .ext_low  (ext_pk[p]),
      .float_lvl(float_lvl0),
      .latch_q  (latch_pk[p]),
      .pin      (pin_pk[p]),
      .alt_i    (alt_pk[p]),
      .drv_lo   (drv_lo_pk[p]),
      .drv_hi   (drv_hi_pk[p])
    );
  end

  // Only the alternate-function variant produces nonzero alternate inputs.
  always_comb begin
    alt_in = '0;
    for (int p = 0; p < NUM_PORTS; p++) alt_in = alt_in | alt_pk[p];
  end

  qbp_read_mux #(.WIDTH(W), .NPORT(NUM_PORTS)) u_rd (
    .latch_pk (latch_pk),
    .pin_pk   (pin_pk),
    .sel      (rd_port),
    .use_latch(rd_latch),
    .data     (rd_data)
  );

  assign pin0 = pin_pk[0];
  assign pin1 = pin_pk[1];
  assign pin2 = pin_pk[2];
  assign pin3 = pin_pk[3];

endmodule

// File: rtl/qbp_port_group_chk.sv
module qbp_port_group_chk #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_port,
  input logic [W-1:0]        wr_data,
  input logic [1:0]          rd_port,
  input logic                rd_latch,
  input logic [W-1:0]        rd_data,
  input logic                bus_mode,
  input logic [W-1:0]        bus_hi,
  input logic [W-1:0]        alt_out,
  input logic [W-1:0]        alt_in,
  input logic [3:0][W-1:0]   latch_pk,
  input logic [3:0][W-1:0]   pin_pk,
  input logic [3:0][W-1:0]   drv_lo_pk,
  input logic [3:0][W-1:0]   drv_hi_pk
);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> latch_pk[$past(wr_port)] == $past(wr_data));

  // R2
  latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(latch_pk));

  // R3
  read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |-> rd_data == latch_pk[rd_port]);

  // R3
  read_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_latch |-> rd_data == pin_pk[rd_port]);

  // R4
  plain_zero_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pk[1] & ~latch_pk[1]) == '0);

  // R5
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> drv_hi_pk[0] == '0);

  // R7
  hi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> (pin_pk[2] & ~bus_hi) == '0);

  // R8
  alt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pk[3] & ~(latch_pk[3] & alt_out)) == '0);

  // R9
  alt_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_in & ~(latch_pk[3] & alt_out)) == '0 && (alt_in & ~pin_pk[3]) == '0);

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hi_pk[0] & drv_lo_pk[0]) == '0 && (drv_hi_pk[1] & drv_lo_pk[1]) == '0 &&
    (drv_hi_pk[2] & drv_lo_pk[2]) == '0 && (drv_hi_pk[3] & drv_lo_pk[3]) == '0);

endmodule

bind qbp_port_group qbp_port_group_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_port  (wr_port),
  .wr_data  (wr_data),
  .rd_port  (rd_port),
  .rd_latch (rd_latch),
  .rd_data  (rd_data),
  .bus_mode (bus_mode),
  .bus_hi   (bus_hi),
  .alt_out  (alt_out),
  .alt_in   (alt_in),
  .latch_pk (latch_pk),
  .pin_pk   (pin_pk),
  .drv_lo_pk(drv_lo_pk),
  .drv_hi_pk(drv_hi_pk)
);

// File: tb/test_qbp_port_group.sv
module test_qbp_port_group;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] port;
    logic [7:0] wdata;
    logic [7:0] ext;
    logic [7:0] aux;   // float level for port 0, alternate outputs for port 3
    logic [7:0] exp;   // expected pin levels
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 8'hA5, 8'h00, 8'h00, 8'hA5},
    '{2'd1, 8'hFF, 8'h0F, 8'h00, 8'hF0},
    '{2'd1, 8'hF0, 8'h3C, 8'h00, 8'hC0},
    '{2'd0, 8'hFF, 8'h00, 8'hFF, 8'hFF},
    '{2'd0, 8'hFF, 8'h00, 8'h5A, 8'h5A},
    '{2'd0, 8'h0F, 8'h01, 8'hFF, 8'h0E},
    '{2'd2, 8'hC3, 8'h00, 8'h00, 8'hC3},
    '{2'd2, 8'hFF, 8'h81, 8'h00, 8'h7E},
    '{2'd3, 8'hFF, 8'h00, 8'hFF, 8'hFF},
    '{2'd3, 8'hFF, 8'h00, 8'h3C, 8'h3C},
    '{2'd3, 8'h0F, 8'h00, 8'h33, 8'h03},
    '{2'd3, 8'hFF, 8'h10, 8'hF0, 8'hE0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_port = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_port = '0;
  logic       rd_latch = 1'b0;
  logic [7:0] rd_data;
  logic       bus_mode = 1'b0;
  logic       bus_lo_oe = 1'b0;
  logic [7:0] bus_lo = '0;
  logic [7:0] bus_hi = '0;
  logic [7:0] alt_out = 8'hFF;
  logic [7:0] alt_in;
  logic [7:0] ext_low0 = '0, ext_low1 = '0, ext_low2 = '0, ext_low3 = '0;
  logic [7:0] float_lvl0 = 8'hA5;
  logic [7:0] pin0, pin1, pin2, pin3;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbp_port_group i_qbp_port_group (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .rd_port(rd_port), .rd_latch(rd_latch), .rd_data(rd_data),
    .bus_mode(bus_mode), .bus_lo_oe(bus_lo_oe), .bus_lo(bus_lo), .bus_hi(bus_hi),
    .alt_out(alt_out), .alt_in(alt_in),
    .ext_low0(ext_low0), .ext_low1(ext_low1), .ext_low2(ext_low2), .ext_low3(ext_low3),
    .float_lvl0(float_lvl0), .pin0(pin0), .pin1(pin1), .pin2(pin2), .pin3(pin3)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic write_latch(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic read_port(input logic [1:0] p, input logic use_latch, output logic [7:0] d);
    rd_port = p; rd_latch = use_latch;
    #1;
    d = rd_data;
  endtask

  task automatic set_ext(input logic [1:0] p, input logic [7:0] v);
    ext_low0 = (p == 2'd0) ? v : 8'h00;
    ext_low1 = (p == 2'd1) ? v : 8'h00;
    ext_low2 = (p == 2'd2) ? v : 8'h00;
    ext_low3 = (p == 2'd3) ? v : 8'h00;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    for (int p = 0; p < 4; p++) begin
      read_port(2'(p), 1'b1, d);
      check("R1 latch reset", d, 8'hFF);
    end
    check("R1 pin1 idle", pin1, 8'hFF);
    check("R1 pin2 idle", pin2, 8'hFF);
    check("R1 pin3 idle", pin3, 8'hFF);
    check("R1 pin0 float", pin0, 8'hA5);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R4 (ports 1,2), R5 (port 0), R8/R9 (port 3), R3 latch path
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].port == 2'd0) float_lvl0 = VECS[i].aux;
      if (VECS[i].port == 2'd3) alt_out = VECS[i].aux;
      set_ext(VECS[i].port, VECS[i].ext);
      write_latch(VECS[i].port, VECS[i].wdata);
      read_port(VECS[i].port, 1'b0, d);
      case (VECS[i].port)
        2'd0: check("R5 table pin", d, VECS[i].exp);
        2'd3: check("R8 table pin", d, VECS[i].exp);
        default: check("R4 table pin", d, VECS[i].exp);
      endcase
      read_port(VECS[i].port, 1'b1, d);
      check("R3 table latch", d, VECS[i].wdata);
      if (VECS[i].port == 2'd3) check("R9 table alt_in", alt_in, VECS[i].exp);
    end
    set_ext(2'd0, 8'h00);
    alt_out = 8'hFF;

    // R3: pin path versus latch path with an external sink
    write_latch(2'd1, 8'hFF);
    set_ext(2'd1, 8'h55);
    read_port(2'd1, 1'b0, d);
    check("R3 pin path", d, 8'hAA);
    read_port(2'd1, 1'b1, d);
    check("R3 latch path", d, 8'hFF);
    set_ext(2'd1, 8'h00);

    // R2: isolation, hold, and read in the cycle before the write edge
    write_latch(2'd0, 8'h11);
    write_latch(2'd2, 8'h22);
    write_latch(2'd3, 8'h33);
    write_latch(2'd1, 8'h12);
    read_port(2'd0, 1'b1, d); check("R2 port0 untouched", d, 8'h11);
    read_port(2'd2, 1'b1, d); check("R2 port2 untouched", d, 8'h22);
    read_port(2'd3, 1'b1, d); check("R2 port3 untouched", d, 8'h33);
    repeat (4) @(negedge clk);
    read_port(2'd1, 1'b1, d); check("R2 hold", d, 8'h12);
    check("R2 pin follows latch", pin1, 8'h12);
    @(negedge clk);
    wr_en = 1'b1; wr_port = 2'd1; wr_data = 8'hC4;
    read_port(2'd1, 1'b1, d); check("R2 old value before edge", d, 8'h12);
    @(negedge clk);
    wr_en = 1'b0;
    read_port(2'd1, 1'b1, d); check("R2 new value after edge", d, 8'hC4);
    check("R2 pin same cycle", pin1, 8'hC4);

    // R5: open-drain with latch 0 never reads high
    float_lvl0 = 8'hFF;
    write_latch(2'd0, 8'h00);
    check("R5 latch zero", pin0, 8'h00);

    // R6: bus mode on port 0
    bus_mode = 1'b1; bus_lo_oe = 1'b1; bus_lo = 8'h3C;
    set_ext(2'd0, 8'hFF);
    check("R6 bus drive", pin0, 8'h3C);
    bus_lo_oe = 1'b0; float_lvl0 = 8'hF0;
    set_ext(2'd0, 8'h00);
    check("R6 released", pin0, 8'hF0);
    set_ext(2'd0, 8'h30);
    check("R6 released sink", pin0, 8'hC0);
    read_port(2'd0, 1'b1, d); check("R6 latch kept", d, 8'h00);
    set_ext(2'd0, 8'h00);

    // R10: write port 0 while bus drives it
    bus_lo_oe = 1'b1; bus_lo = 8'h96;
    write_latch(2'd0, 8'h5A);
    check("R10 pins stay on bus", pin0, 8'h96);
    read_port(2'd0, 1'b1, d); check("R10 latch written", d, 8'h5A);

    // R7: high-address port
    write_latch(2'd2, 8'h00);
    bus_hi = 8'hA5; #1;
    check("R7 addr out", pin2, 8'hA5);
    set_ext(2'd2, 8'h01);
    check("R7 addr sunk", pin2, 8'hA4);
    set_ext(2'd2, 8'h00);
    bus_mode = 1'b0; bus_lo_oe = 1'b0; float_lvl0 = 8'hFF; #1;
    check("R7 latch resumes", pin2, 8'h00);
    check("R10 latch governs after bus", pin0, 8'h5A);

    // R9: latch 0 blocks alternate input
    alt_out = 8'hFF;
    write_latch(2'd3, 8'h00);
    check("R9 alt_in blocked", alt_in, 8'h00);
    write_latch(2'd3, 8'hFF);
    alt_out = 8'h0F; #1;
    check("R9 alt_in gated by alt_out", alt_in, 8'h0F);

    done = 1'b1;
    report();
  end

endmodule